// File: doc/BRIEF.md
# 8-bit Accumulator Processor Core

This block is a small multi-cycle processor. It has an 8-bit accumulator, an 8-bit address pointer, a stack pointer and a program counter. A single 128-byte memory inside the core holds the program, its data and its stack. Each instruction is one byte. Bit 0 of that byte says whether a second byte follows, and the second byte carries either a memory address or a constant. The core supports four ways of reaching an operand: a direct address, the location the address pointer names, an immediate constant, and the stack, with a predecrementing push and a postincrementing pop. Branches test a two-bit flag register that holds carry and zero.

Before the core runs, a test environment fills the memory through a preload port while reset is held. Reset is then released, and the core executes from address 0 until it meets the halt byte. The core reads the outside world through an 8-bit input port and shows results on an 8-bit output register. A one-byte instruction takes two cycles: fetch, then execute. A two-byte instruction takes three cycles: fetch, operand fetch, then execute.

Top module: `acc8_core`

## Requirements
- R1: Synchronous active-high reset clears PC, A, AP, SP, the flags and the output register to zero, and leaves the core not halted.
- R2: An instruction byte is split as op=[7:4], am=[3:2], r1=bit 1 and r0=bit 0. When r0 is 1, the next byte is the operand and is never executed as an instruction. PC advances by one for every byte that is fetched.
- R3: Load (op 1) writes A (r1=0) or AP (r1=1). With am=00 the source is the memory byte at the address in the operand. With am=01 the source is the byte at M[AP]. With am=10 the source is the constant in the operand.
- R4: Store (op 2) with am=00 writes A (r1=0) or AP (r1=1) to the memory byte at the address in the operand.
- R5: Push (op 2, am=11) first decrements SP and then writes A or AP to M[SP]. After reset, the first push lands at address 127. Pop (op 1, am=11) reads M[SP] into A or AP and then increments SP.
- R6: Add (op 3) and subtract (op 4) combine A with a direct, M[AP] or immediate operand. With am=10 and r1=1 they act on AP instead of A. Both set carry (status bit 1) to the carry out or to the borrow, and set zero (status bit 0) when the 8-bit result is zero.
- R7: Or (op 6), and (op 7) and xor (op 8) combine A with a direct, M[AP] or immediate operand. Not (op 5) inverts A. These four set the zero flag from the result and leave carry unchanged.
- R8: Shift (op 9) moves A right by one and fills bit 7 with zero. Carry takes the bit shifted out, and zero is set from the result.
- R9: Branch (op A) takes its target from the second byte. am=00 always jumps. am=01 jumps only when zero is set. am=10 jumps only when carry is set. A branch that is not taken continues with the next instruction.
- R10: Call (byte 0xC1) pushes the address that follows the call and then jumps to its operand. Return (byte 0xB0) pops PC from the stack.
- R11: Byte 0xD0 loads A from the input port. Byte 0xE0 copies A to the output port. Nothing else changes the output port.
- R12: Byte 0x02 halts the core. The halted output then stays high and all state stays frozen until reset. Byte 0x00 does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | 8 | Byte read by the input instruction |
| out_port | output | 8 | Output register, written by the output instruction |
| halted | output | 1 | High once the halt byte has executed |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 7 | Preload byte address |
| pl_data | input | 8 | Preload byte value |

## Verification
The bench builds the core with an 8-bit data path and a 7-bit address, which gives a full 128-byte memory. With that size, the wrap of SP from 0 down to address 127 on the first push can be observed. It also lets programs keep data near the top of memory, apart from the code and from a shared trap routine at 0x78. Each program observes flags, stack contents and AP only through the output port: a branch whose outcome is wrong lands in the trap routine, and the trap routine emits an unexpected value.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        OP_SYS  = 4'h0, OP_LD   = 4'h1, OP_ST  = 4'h2, OP_ADD = 4'h3,
        OP_SUB  = 4'h4, OP_NOT  = 4'h5, OP_OR  = 4'h6, OP_AND = 4'h7,
        OP_XOR  = 4'h8, OP_SHR  = 4'h9, OP_BR  = 4'hA, OP_RET = 4'hB,
        OP_CALL = 4'hC, OP_IN   = 4'hD, OP_OUT = 4'hE, OP_RSV = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {AM_DIR = 2'd0, AM_IND = 2'd1, AM_IMM = 2'd2, AM_STK = 2'd3} amode_e;

    typedef enum logic [1:0] {ST_FETCH, ST_OPND, ST_EXEC, ST_HALT} state_e;

    typedef enum logic [2:0] {FN_ADD, FN_SUB, FN_OR, FN_AND, FN_XOR, FN_NOT, FN_SHR, FN_PASS} alu_fn_e;

    typedef struct packed {
        opcode_e op;
        amode_e  am;
        logic    r1;
        logic    r0;
    } instr_t;

    typedef struct packed {
        logic c;
        logic z;
    } flags_t;

    localparam logic [7:0] HALT_BYTE = 8'h02;

    function automatic alu_fn_e alu_fn_of(opcode_e op);
        case (op)
            OP_ADD:  return FN_ADD;
            OP_SUB:  return FN_SUB;
            OP_OR:   return FN_OR;
            OP_AND:  return FN_AND;
            OP_XOR:  return FN_XOR;
            OP_NOT:  return FN_NOT;
            OP_SHR:  return FN_SHR;
            default: return FN_PASS;
        endcase
    endfunction

    function automatic logic is_alu_op(opcode_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_OR) || (op == OP_AND) ||
               (op == OP_XOR) || (op == OP_NOT) || (op == OP_SHR);
    endfunction
endpackage

// File: rtl/acc8_mem.sv
module acc8_mem #(
    parameter int DW = acc8_pkg::DATA_W,
    parameter int AW = acc8_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

    // R4: a written byte can be read back on the next cycle
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        we |=> (cells[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_fn_e       fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c_in,
    output logic [DW-1:0] y,
    output logic          c_out,
    output logic          z_out
);
    logic [DW:0] wide;

    always_comb begin
        c_out = c_in;
        y     = a;
        wide  = '0;
        case (fn)
            FN_ADD: begin wide = {1'b0, a} + {1'b0, b}; y = wide[DW-1:0]; c_out = wide[DW]; end
            FN_SUB: begin wide = {1'b0, a} - {1'b0, b}; y = wide[DW-1:0]; c_out = wide[DW]; end
            FN_OR:  y = a | b;
            FN_AND: y = a & b;
            FN_XOR: y = a ^ b;
            FN_NOT: y = ~a;
            FN_SHR: begin y = {1'b0, a[DW-1:1]}; c_out = a[0]; end
            default: y = b;
        endcase
    end

    assign z_out = (y == '0);
endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int DATA_W_P = DATA_W,
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W_P-1:0] in_port,
    output logic [DATA_W_P-1:0] out_port,
    output logic                halted,
    input  logic                pl_we,
    input  logic [ADDR_W_P-1:0] pl_addr,
    input  logic [DATA_W_P-1:0] pl_data
);
    localparam int DW = DATA_W_P;
    localparam int AW = ADDR_W_P;
    localparam logic [DW-1:0] ONE = DW'(1);

    state_e        st;
    instr_t        ir;
    flags_t        fl;
    logic [DW-1:0] pc, acc, ap, sp, md, outr;

    logic [DW-1:0] rdata, core_wdata, sp_dec, sp_inc, ld_val, alu_a, alu_b, alu_y;
    logic [AW-1:0] raddr, core_waddr;
    logic          core_we, to_ap, alu_c, alu_z, take;
    instr_t        fb;

    assign fb     = instr_t'(rdata);
    assign sp_dec = sp - ONE;
    assign sp_inc = sp + ONE;

    // read address selection
    always_comb begin
        raddr = pc[AW-1:0];
        if (st == ST_EXEC) begin
            if (ir.am == AM_STK || ir.op == OP_RET) raddr = sp[AW-1:0];
            else if (ir.am == AM_IND)               raddr = ap[AW-1:0];
            else                                    raddr = md[AW-1:0];
        end
    end

    // core write port: direct store, push, call
    always_comb begin
        core_we    = 1'b0;
        core_waddr = md[AW-1:0];
        core_wdata = ir.r1 ? ap : acc;
        if (st == ST_EXEC) begin
            if (ir.op == OP_ST && ir.am == AM_DIR) core_we = 1'b1;
            if (ir.op == OP_ST && ir.am == AM_STK) begin
                core_we    = 1'b1;
                core_waddr = sp_dec[AW-1:0];
            end
            if (ir.op == OP_CALL) begin
                core_we    = 1'b1;
                core_waddr = sp_dec[AW-1:0];
                core_wdata = pc;
            end
        end
    end

    acc8_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (pl_we | core_we),
        .waddr (pl_we ? pl_addr : core_waddr),
        .wdata (pl_we ? pl_data : core_wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign to_ap  = ir.r1 && ir.am == AM_IMM && (ir.op == OP_ADD || ir.op == OP_SUB);
    assign alu_a  = to_ap ? ap : acc;
    assign alu_b  = (ir.am == AM_IMM) ? md : rdata;
    assign ld_val = (ir.am == AM_IMM) ? md : rdata;

    acc8_alu #(.DW(DW)) u_alu (
        .fn    (alu_fn_of(ir.op)),
        .a     (alu_a),
        .b     (alu_b),
        .c_in  (fl.c),
        .y     (alu_y),
        .c_out (alu_c),
        .z_out (alu_z)
    );

    always_comb begin
        case (ir.am)
            AM_DIR:  take = 1'b1;
            AM_IND:  take = fl.z;
            AM_IMM:  take = fl.c;
            default: take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_FETCH;
            ir   <= '0;
            fl   <= '0;
            pc   <= '0;
            acc  <= '0;
            ap   <= '0;
            sp   <= '0;
            md   <= '0;
            outr <= '0;
        end else begin
            case (st)
                ST_FETCH: begin
                    ir <= fb;
                    pc <= pc + ONE;
                    st <= fb.r0 ? ST_OPND : ST_EXEC;
                end
                ST_OPND: begin
                    md <= rdata;
                    pc <= pc + ONE;
                    st <= ST_EXEC;
                end
                ST_EXEC: begin
                    st <= ST_FETCH;
                    if (is_alu_op(ir.op)) begin
                        if (to_ap) ap <= alu_y;
                        else       acc <= alu_y;
                        fl <= '{c: alu_c, z: alu_z};
                    end
                    case (ir.op)
                        OP_SYS:  if (ir == instr_t'(HALT_BYTE)) st <= ST_HALT;
                        OP_LD: begin
                            if (ir.r1) ap <= ld_val;
                            else       acc <= ld_val;
                            if (ir.am == AM_STK) sp <= sp_inc;
                        end
                        OP_ST:   if (ir.am == AM_STK) sp <= sp_dec;
                        OP_BR:   if (take) pc <= md;
                        OP_RET: begin
                            pc <= rdata;
                            sp <= sp_inc;
                        end
                        OP_CALL: begin
                            sp <= sp_dec;
                            pc <= md;
                        end
                        OP_IN:   acc <= in_port;
                        OP_OUT:  outr <= acc;
                        default: ;
                    endcase
                end
                default: st <= ST_HALT;
            endcase
        end
    end

    assign out_port = outr;
    assign halted   = (st == ST_HALT);

    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_push_predec_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && ir.op == OP_ST && ir.am == AM_STK) |=> (sp == $past(sp) - ONE));

    assert_pop_postinc_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && ir.op == OP_LD && ir.am == AM_STK) |=> (sp == $past(sp) + ONE));

    assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH) |=> (pc == $past(pc) + ONE));

    assert_out_only_by_e0_R11: assert property (@(posedge clk) disable iff (rst)
        !(st == ST_EXEC && ir.op == OP_OUT) |=> $stable(out_port));

    assert_shr_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && ir.op == OP_SHR) |=> (acc[DW-1] == 1'b0 && fl.c == $past(acc[0])));
endmodule

// File: tb/acc8_core_tb.sv
`timescale 1ns/1ps
module acc8_core_tb;
    localparam logic [7:0] BAD = 8'h78;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_port = 8'hC3;
    logic [7:0] out_port;
    logic       halted;
    logic       pl_we = 1'b0;
    logic [6:0] pl_addr = '0;
    logic [7:0] pl_data = '0;

    int checks = 0;
    int fails  = 0;

    logic [7:0] prog [128];
    int         wp;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] prev_out;

    always #2 clk = ~clk;

    acc8_core #(.DATA_W_P(8), .ADDR_W_P(7)) u_dut (
        .clk(clk), .rst(rst), .in_port(in_port), .out_port(out_port),
        .halted(halted), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
    );

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
        end
    endtask

    // monitor: every change on the output port pops one expected item
    always @(negedge clk) begin
        if (rst) prev_out = 8'h00;
        else if (out_port !== prev_out) begin
            if (exp_q.size() == 0) chk(1'b0, "unexpected output", out_port, 8'h00);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_port === e, t, out_port, e);
            end
            prev_out = out_port;
        end
    end

    task automatic expect_out(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 128; i++) prog[i] = 8'h00;
        // trap routine: a wrong branch emits EE and halts
        prog[BAD]     = 8'h19;
        prog[BAD + 1] = 8'hEE;
        prog[BAD + 2] = 8'hE0;
        prog[BAD + 3] = 8'h02;
        wp = 0;
    endtask

    task automatic b1(input logic [7:0] x);
        prog[wp] = x; wp++;
    endtask

    task automatic b2(input logic [7:0] x, input logic [7:0] y);
        prog[wp] = x; prog[wp + 1] = y; wp += 2;
    endtask

    task automatic must_take(input logic [7:0] opc);
        logic [7:0] t;
        t = 8'(wp + 4);
        b2(opc, t);
        b2(8'hA1, BAD);
    endtask

    task automatic must_not(input logic [7:0] opc);
        b2(opc, BAD);
    endtask

    task automatic run_prog(input string name);
        bit done;
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 128; i++) begin
            pl_we = 1'b1; pl_addr = 7'(i); pl_data = prog[i];
            @(negedge clk);
        end
        pl_we = 1'b0;
        @(negedge clk);
        chk(out_port === 8'h00 && halted === 1'b0, {"R1 reset state before ", name}, out_port, 8'h00);
        rst = 1'b0;
        done = 1'b0;
        for (int n = 0; n < 3000 && !done; n++) begin
            @(negedge clk);
            done = halted;
        end
        chk(halted === 1'b1, {"R12 watchdog/halt reached in ", name}, {7'd0, halted}, 8'h01);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, {"outputs missing in ", name}, 8'(exp_q.size()), 8'h00);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);

        // P1: loads, stores, I/O (R2 R3 R4 R11)
        clear_prog();
        b2(8'h19, 8'h5A); b1(8'hE0);          expect_out(8'h5A, "R3 load immediate");
        b2(8'h21, 8'h60);
        b2(8'h19, 8'h11); b1(8'hE0);          expect_out(8'h11, "R11 out copies A");
        b2(8'h1B, 8'h60); b1(8'h14); b1(8'hE0); expect_out(8'h5A, "R4 store direct / R3 load via AP");
        b2(8'h39, 8'h01); b1(8'hE0);          expect_out(8'h5B, "R2 operand byte fetched");
        b2(8'h23, 8'h61); b2(8'h11, 8'h61); b1(8'hE0); expect_out(8'h60, "R4 store AP direct");
        b2(8'h13, 8'h60); b2(8'h23, 8'h62); b2(8'h11, 8'h62); b1(8'hE0); expect_out(8'h5A, "R3 load AP direct");
        b1(8'hD0); b1(8'hE0);                 expect_out(8'hC3, "R11 input port");
        b1(8'h02);
        run_prog("loads");

        // P2: stack (R5)
        clear_prog();
        b2(8'h19, 8'h21); b1(8'h2C);
        b2(8'h19, 8'h44); b1(8'h2C);
        b2(8'h11, 8'h7E); b1(8'hE0);          expect_out(8'h44, "R5 second push at 126");
        b2(8'h11, 8'h7F); b1(8'hE0);          expect_out(8'h21, "R5 first push at 127");
        b1(8'h1C); b1(8'hE0);                 expect_out(8'h44, "R5 pop newest first");
        b1(8'h1C); b1(8'hE0);                 expect_out(8'h21, "R5 pop older");
        b2(8'h1B, 8'h37); b1(8'h2E); b1(8'h1C); b1(8'hE0); expect_out(8'h37, "R5 push AP");
        b2(8'h19, 8'h38); b1(8'h2C); b1(8'h1E);
        b2(8'h23, 8'h62); b2(8'h11, 8'h62); b1(8'hE0); expect_out(8'h38, "R5 pop AP");
        b1(8'h02);
        run_prog("stack");

        // P3: add and subtract (R6)
        clear_prog();
        b2(8'h19, 8'hF0); b2(8'h39, 8'h20); must_take(8'hA9);
        b1(8'hE0);                            expect_out(8'h10, "R6 add carry out");
        b2(8'h49, 8'h10); must_take(8'hA5); must_not(8'hA9);
        b2(8'h19, 8'h77); b1(8'hE0);          expect_out(8'h77, "R6 sub zero no borrow");
        b2(8'h1B, 8'h50); b2(8'h3B, 8'h05); b2(8'h4B, 8'h02);
        b2(8'h23, 8'h63); b2(8'h11, 8'h63); b1(8'hE0); expect_out(8'h53, "R6 AP immediate add/sub");
        b2(8'h19, 8'h03); b2(8'h49, 8'h05); must_take(8'hA9);
        b1(8'hE0);                            expect_out(8'hFE, "R6 sub borrow");
        b2(8'h1B, 8'h63); b2(8'h19, 8'h01); b1(8'h34); b1(8'hE0); expect_out(8'h54, "R6 add via AP");
        b1(8'h44); b1(8'hE0);                 expect_out(8'h01, "R6 sub via AP");
        b2(8'h31, 8'h63); b1(8'hE0);          expect_out(8'h54, "R6 add direct");
        b1(8'h02);
        run_prog("arith");

        // P4: logic, shift, branches (R7 R8 R9)
        clear_prog();
        b2(8'h19, 8'hFF); b2(8'h39, 8'h01);
        b2(8'h19, 8'hF0); b2(8'h69, 8'h0F); b1(8'hE0); expect_out(8'hFF, "R7 or immediate");
        b2(8'h79, 8'h3C); b1(8'hE0);          expect_out(8'h3C, "R7 and immediate");
        b2(8'h89, 8'hFF); b1(8'hE0);          expect_out(8'hC3, "R7 xor immediate");
        b1(8'h50); b1(8'hE0);                 expect_out(8'h3C, "R7 not");
        b2(8'h89, 8'h3C); must_take(8'hA5); must_take(8'hA9);
        b2(8'h19, 8'h99); b1(8'hE0);          expect_out(8'h99, "R7 zero set, carry kept");
        b2(8'h69, 8'h00); must_not(8'hA5);
        b2(8'h19, 8'h81); b1(8'h90); must_take(8'hA9);
        b1(8'hE0);                            expect_out(8'h40, "R8 shift carry out");
        b1(8'h90); must_not(8'hA9); b1(8'hE0); expect_out(8'h20, "R8 shift zero fill");
        b2(8'h19, 8'h01); b1(8'h90); must_take(8'hA5); must_take(8'hA9);
        b2(8'h19, 8'h5E); b1(8'hE0);          expect_out(8'h5E, "R9 jz and jc taken");
        b2(8'h1B, 8'h70); b2(8'h19, 8'hC0); b2(8'h21, 8'h70);
        b2(8'h19, 8'h0F); b1(8'h64); b1(8'hE0); expect_out(8'hCF, "R7 or via AP");
        b1(8'h74); b1(8'hE0);                 expect_out(8'hC0, "R7 and via AP");
        b1(8'h84); b1(8'hE0);                 expect_out(8'h00, "R7 xor via AP");
        b1(8'h02);
        run_prog("logic");

        // P5: call and return (R10)
        clear_prog();
        b2(8'h19, 8'h12); b2(8'hC1, 8'h40); b1(8'hE0); b1(8'h02);
        expect_out(8'h04, "R10 return address pushed");
        expect_out(8'h23, "R10 return resumes after call");
        wp = 8'h40;
        b2(8'h11, 8'h7F); b1(8'hE0); b2(8'h19, 8'h23); b1(8'hB0);
        run_prog("call");

        // P6: nop, operand 0x02 not executed, halt (R2 R12)
        clear_prog();
        b1(8'h00); b1(8'h00);
        b2(8'h19, 8'h02); b1(8'hE0);          expect_out(8'h02, "R2 operand 02 not halt / R12 nop");
        b2(8'h19, 8'h66); b1(8'hE0);          expect_out(8'h66, "R12 before halt");
        b1(8'h02);
        b2(8'h19, 8'h99); b1(8'hE0); b1(8'h02);
        run_prog("halt");
        repeat (20) @(negedge clk);
        chk(halted === 1'b1, "R12 halt sticky", {7'd0, halted}, 8'h01);
        chk(out_port === 8'h66, "R12 state frozen after halt", out_port, 8'h66);

        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(halted === 1'b0 && out_port === 8'h00, "R1 reset clears halt", out_port, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule